// File: doc/BRIEF.md
# Static Memory Access Timing Engine

This block sets the cycle-level timing of accesses to external static memories such as flash and SRAM. A request carries an address, a direction, a page flag and write data. The block picks one of four chip selects from the two top address bits. Chip selects 0 and 3 can swap their decode, and that choice is latched from a boot input while reset is asserted. Each chip select has its own protocol mode and its own wait-state settings. The block drives the chip select, output-enable, write-enable and address-valid strobes for the number of cycles those settings give.

In modes 0, 4 and 5 a per-chip-select enable can also make an access wait for an external ready line, which passes through a synchronizer first. A programmable limit ends an access whose ready line never rises, and that access is flagged as an error. Between accesses the block can add idle turnaround cycles. When no access is running it keeps the data bus driven with the last value seen on it, and it delays the return of read data to the bus.

Top module: `smem_wait_engine`

## Requirements
- R1: With the ready input unused, a read lasts (read wait + 1) cycles with chip select and output enable low, and the done pulse comes (read wait + 2) cycles after the request is accepted.
- R2: A read with the page flag set uses the page wait field only when the chip select's mode is 1, 2 or 3. In any other mode the page flag has no effect and the read wait field applies.
- R3: A write lasts (write length + 1) cycles with chip select and write enable low and output enable high. Output enable and write enable are never low together.
- R4: In modes 0, 4 and 5 with the chip select's handshake enable set, the access ends only after the internal count has expired and the synchronized ready is high. A ready that rises between edges takes effect on the third edge after it rises.
- R5: In modes 1, 2, 3 and 7 the ready input is never sampled, whatever the handshake enable holds. The same applies in any mode whose handshake enable is clear.
- R6: If the ready input is still low after the wait count plus the timeout limit in cycles, the access ends. Its done pulse carries the error flag. The error flag is never high without the done pulse.
- R7: When the previous access was a read and the new access goes to a different chip select or is a write, the previous chip select's turnaround count adds that many idle cycles before the new access starts.
- R8: When the new chip select has its extended turnaround bit set and matches the previous chip select, its turnaround count adds that many cycles of chip-select negation, in either direction.
- R9: When idle, the bus is driven with the last written data. After a read, the bus stays released for max(1, turnaround) cycles after the done pulse and is then driven with the read data.
- R10: With dynamic wait mode on, every access lasts one extra cycle and address valid stays low for two cycles instead of one.
- R11: The swap bit is latched from the boot input during reset. When it is set, address region 0 selects chip select 3 and region 3 selects chip select 0. A later change of the boot input has no effect.
- R12: After reset all chip selects and strobes are high, the request is ready, done and error are low and the bus is driven. At most one chip select is ever low.
- R13: The done pulse lasts exactly one cycle, and the read data is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bootSwap | input | 1 | Boot value of the chip-select 0/3 swap, latched in reset |
| reqValid | input | 1 | Access request valid |
| reqReady | output | 1 | Engine can accept a request |
| reqAddr | input | ADDR_W | Access address; top two bits pick the region |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqPage | input | 1 | Read is a page access |
| reqWdata | input | DATA_W | Write data |
| cfgMode | input | 4*3 | Protocol mode per chip select |
| cfgRdWait | input | 4*WAIT_W | Read wait cycles per chip select |
| cfgPgWait | input | 4*WAIT_W | Page read wait cycles per chip select |
| cfgWrLen | input | 4*WAIT_W | Write enable length per chip select |
| cfgTurn | input | 4*WAIT_W | Turnaround cycles per chip select |
| cfgTurnExt | input | 4 | Turnaround as same-chip-select negation time |
| cfgHsEn | input | 4 | Handshake enable per chip select |
| cfgDynWait | input | 1 | Dynamic wait mode, adds one cycle |
| cfgTimeout | input | TO_W | Cycles to wait for ready before abort |
| memRdy | input | 1 | Asynchronous ready from memory |
| memDataIn | input | DATA_W | Data from memory |
| memCsN | output | 4 | Active-low chip selects |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memAdvN | output | 1 | Active-low address valid |
| memAddr | output | ADDR_W | Latched access address |
| memDataOut | output | DATA_W | Data driven onto the bus |
| memDataOe | output | 1 | Bus drive enable |
| doneP | output | 1 | One-cycle access-complete pulse |
| rdData | output | DATA_W | Read data, valid with doneP |
| accErr | output | 1 | Access aborted by timeout, valid with doneP |

## Verification
Every latency is counted from the clock edge that accepts a request. Strobes and the done pulse are sampled on the falling edge after each rising edge, so the count at which doneP is first seen equals the number of edges since acceptance. That count should be wait + 2, plus any turnaround cycles, plus one in dynamic mode. For an access waiting on ready, it is the larger of wait + 2 and three edges after the edge on which ready rose. Write-back is checked relative to the done sample: the bus is still released one sample before max(1, turnaround) cycles have passed and is driven with the read data at exactly that count.

// File: rtl/smem_wait_pkg.sv
package smem_wait_pkg;
  localparam int NCS  = 4;
  localparam int CS_W = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_ACC} wseStateT;

  typedef struct packed {
    logic accept;
    logic readActive;
    logic writeActive;
    logic rdFinish;
    logic wrFinish;
  } wseStrbT;

  function automatic logic modeUsesReady(input logic [2:0] m);
    return (m == 3'd0) || (m == 3'd4) || (m == 3'd5);
  endfunction

  function automatic logic modeHasPage(input logic [2:0] m);
    return (m == 3'd1) || (m == 3'd2) || (m == 3'd3);
  endfunction
endpackage

// File: rtl/smem_wait_ctrl.sv
module smem_wait_ctrl
  import smem_wait_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int TO_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bootSwap,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [CS_W-1:0]       reqRegion,
  input  logic                  reqWrite,
  input  logic                  reqPage,
  input  logic [NCS*3-1:0]      cfgMode,
  input  logic [NCS*WAIT_W-1:0] cfgRdWait,
  input  logic [NCS*WAIT_W-1:0] cfgPgWait,
  input  logic [NCS*WAIT_W-1:0] cfgWrLen,
  input  logic [NCS*WAIT_W-1:0] cfgTurn,
  input  logic [NCS-1:0]        cfgTurnExt,
  input  logic [NCS-1:0]        cfgHsEn,
  input  logic                  cfgDynWait,
  input  logic [TO_W-1:0]       cfgTimeout,
  input  logic                  rdySync,
  output logic [NCS-1:0]        memCsN,
  output logic                  memOeN,
  output logic                  memWeN,
  output logic                  memAdvN,
  output logic                  doneP,
  output logic                  accErr,
  output wseStrbT               strb,
  output logic [WAIT_W-1:0]     wbLen
);
  localparam int CNT_W = WAIT_W + 1;

  wseStateT         state;
  logic             swapReg;
  logic [CS_W-1:0]  curCs, prevCs, newCs;
  logic             curWrite, prevRead, prevValid, hsAct;
  logic [CNT_W-1:0] waitCnt, waitLd;
  logic [WAIT_W-1:0] gapCnt, gapLd, selWait, turnNew, turnPrev, turnCur;
  logic [TO_W-1:0]  toCnt;
  logic [1:0]       advCnt;
  logic [2:0]       modeNew;
  logic             accept, finish, abortNow;

  // region decode with optional 0/3 exchange
  always_comb begin
    newCs = reqRegion;
    if (swapReg && (reqRegion == 2'd0 || reqRegion == 2'd3)) newCs = ~reqRegion;
  end

  assign modeNew  = cfgMode[newCs*3 +: 3];
  assign turnNew  = cfgTurn[newCs*WAIT_W +: WAIT_W];
  assign turnPrev = cfgTurn[prevCs*WAIT_W +: WAIT_W];
  assign turnCur  = cfgTurn[curCs*WAIT_W +: WAIT_W];

  always_comb begin
    if (reqWrite)                              selWait = cfgWrLen[newCs*WAIT_W +: WAIT_W];
    else if (reqPage && modeHasPage(modeNew))  selWait = cfgPgWait[newCs*WAIT_W +: WAIT_W];
    else                                       selWait = cfgRdWait[newCs*WAIT_W +: WAIT_W];
  end
  assign waitLd = {1'b0, selWait} + CNT_W'(cfgDynWait);

  always_comb begin
    gapLd = '0;
    if (prevValid && cfgTurnExt[newCs] && newCs == prevCs)
      gapLd = turnNew;
    else if (prevValid && prevRead && (newCs != prevCs || reqWrite))
      gapLd = turnPrev;
  end

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;

  // completion decision inside an access
  always_comb begin
    finish   = 1'b0;
    abortNow = 1'b0;
    if (state == ST_ACC && waitCnt == '0) begin
      if (!hsAct || rdySync) finish = 1'b1;
      else if (toCnt == cfgTimeout) begin
        finish   = 1'b1;
        abortNow = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swapReg   <= bootSwap;
      state     <= ST_IDLE;
      curCs     <= '0;
      curWrite  <= 1'b0;
      hsAct     <= 1'b0;
      waitCnt   <= '0;
      gapCnt    <= '0;
      toCnt     <= '0;
      advCnt    <= '0;
      prevValid <= 1'b0;
      prevCs    <= '0;
      prevRead  <= 1'b0;
      doneP     <= 1'b0;
      accErr    <= 1'b0;
    end else begin
      doneP  <= finish;
      accErr <= abortNow;
      unique case (state)
        ST_IDLE: if (accept) begin
          curCs    <= newCs;
          curWrite <= reqWrite;
          hsAct    <= cfgHsEn[newCs] && modeUsesReady(modeNew);
          waitCnt  <= waitLd;
          toCnt    <= '0;
          advCnt   <= cfgDynWait ? 2'd2 : 2'd1;
          gapCnt   <= gapLd;
          state    <= (gapLd == '0) ? ST_ACC : ST_GAP;
        end
        ST_GAP: begin
          if (gapCnt == WAIT_W'(1)) state <= ST_ACC;
          gapCnt <= gapCnt - 1'b1;
        end
        ST_ACC: begin
          if (advCnt != 2'd0) advCnt <= advCnt - 1'b1;
          if (waitCnt != '0) waitCnt <= waitCnt - 1'b1;
          else if (!finish) toCnt <= toCnt + 1'b1;
          if (finish) begin
            state     <= ST_IDLE;
            prevValid <= 1'b1;
            prevCs    <= curCs;
            prevRead  <= !curWrite;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    memCsN = '1;
    if (state == ST_ACC) memCsN[curCs] = 1'b0;
  end
  assign memOeN  = !(state == ST_ACC && !curWrite);
  assign memWeN  = !(state == ST_ACC && curWrite);
  assign memAdvN = !(state == ST_ACC && advCnt != 2'd0);

  assign strb.accept      = accept;
  assign strb.readActive  = (state == ST_ACC) && !curWrite;
  assign strb.writeActive = (state == ST_ACC) && curWrite;
  assign strb.rdFinish    = finish && !curWrite;
  assign strb.wrFinish    = finish && curWrite;
  assign wbLen = (turnCur == '0) ? WAIT_W'(1) : turnCur;

  // R12
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~memCsN));
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!memOeN && !memWeN));
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) doneP |=> !doneP);
  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) accErr |-> doneP);
  // R4
  hs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneP && !accErr && $past(hsAct)) |-> $past(rdySync));
endmodule

// File: rtl/smem_wait_dp.sv
module smem_wait_dp
  import smem_wait_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wseStrbT           strb,
  input  logic [WAIT_W-1:0] wbLen,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              memRdy,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              rdySync,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic [DATA_W-1:0] rdData
);
  logic              rdyMeta;
  logic [DATA_W-1:0] wdataReg, busVal;
  logic [WAIT_W-1:0] wbCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdyMeta  <= 1'b0;
      rdySync  <= 1'b0;
      memAddr  <= '0;
      wdataReg <= '0;
      rdData   <= '0;
      busVal   <= '0;
      wbCnt    <= '0;
    end else begin
      rdyMeta <= memRdy;
      rdySync <= rdyMeta;
      if (strb.accept) begin
        memAddr  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (strb.rdFinish) begin
        rdData <= memDataIn;
        wbCnt  <= wbLen;
      end else if (strb.wrFinish) begin
        busVal <= wdataReg;
        wbCnt  <= '0;
      end else if (wbCnt != '0) begin
        wbCnt <= wbCnt - 1'b1;
        if (wbCnt == WAIT_W'(1)) busVal <= rdData;
      end
    end
  end

  assign memDataOe  = strb.writeActive || (!strb.readActive && wbCnt == '0);
  assign memDataOut = strb.writeActive ? wdataReg : busVal;

  // R9
  wb_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbCnt == WAIT_W'(1) && !strb.rdFinish && !strb.wrFinish && !strb.writeActive)
      |=> (memDataOut == $past(rdData)));
endmodule

// File: rtl/smem_wait_engine.sv
module smem_wait_engine
  import smem_wait_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4,
  parameter int TO_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bootSwap,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic                  reqWrite,
  input  logic                  reqPage,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [NCS*3-1:0]      cfgMode,
  input  logic [NCS*WAIT_W-1:0] cfgRdWait,
  input  logic [NCS*WAIT_W-1:0] cfgPgWait,
  input  logic [NCS*WAIT_W-1:0] cfgWrLen,
  input  logic [NCS*WAIT_W-1:0] cfgTurn,
  input  logic [NCS-1:0]        cfgTurnExt,
  input  logic [NCS-1:0]        cfgHsEn,
  input  logic                  cfgDynWait,
  input  logic [TO_W-1:0]       cfgTimeout,
  input  logic                  memRdy,
  input  logic [DATA_W-1:0]     memDataIn,
  output logic [NCS-1:0]        memCsN,
  output logic                  memOeN,
  output logic                  memWeN,
  output logic                  memAdvN,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memDataOut,
  output logic                  memDataOe,
  output logic                  doneP,
  output logic [DATA_W-1:0]     rdData,
  output logic                  accErr
);
  wseStrbT           strb;
  logic [WAIT_W-1:0] wbLen;
  logic              rdySync;

  smem_wait_ctrl #(.WAIT_W(WAIT_W), .TO_W(TO_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bootSwap(bootSwap),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqRegion(reqAddr[ADDR_W-1 -: CS_W]), .reqWrite(reqWrite), .reqPage(reqPage),
    .cfgMode(cfgMode), .cfgRdWait(cfgRdWait), .cfgPgWait(cfgPgWait), .cfgWrLen(cfgWrLen),
    .cfgTurn(cfgTurn), .cfgTurnExt(cfgTurnExt), .cfgHsEn(cfgHsEn),
    .cfgDynWait(cfgDynWait), .cfgTimeout(cfgTimeout), .rdySync(rdySync),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .memAdvN(memAdvN),
    .doneP(doneP), .accErr(accErr), .strb(strb), .wbLen(wbLen)
  );

  smem_wait_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wbLen(wbLen),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .memRdy(memRdy), .memDataIn(memDataIn),
    .rdySync(rdySync), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .rdData(rdData)
  );
endmodule

// File: tb/smem_wait_engine_tb.sv
module smem_wait_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, bootSwap = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqPage = 1'b0;
  logic [27:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [11:0] cfgMode = '0;
  logic [15:0] cfgRdWait = '0, cfgPgWait = '0, cfgWrLen = '0, cfgTurn = '0;
  logic [3:0]  cfgTurnExt = '0, cfgHsEn = '0;
  logic        cfgDynWait = 1'b0;
  logic [7:0]  cfgTimeout = 8'd20;
  logic        memRdy = 1'b1;
  logic [15:0] memDataIn;
  logic        reqReady, memOeN, memWeN, memAdvN, memDataOe, doneP, accErr;
  logic [3:0]  memCsN;
  logic [27:0] memAddr;
  logic [15:0] memDataOut, rdData;
  int vecs = 0, miss = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign memDataIn = memAddr[15:0] ^ 16'h5A5A;

  smem_wait_engine u_dut (
    .clk(clk), .rst_n(rst_n), .bootSwap(bootSwap), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqPage(reqPage), .reqWdata(reqWdata),
    .cfgMode(cfgMode), .cfgRdWait(cfgRdWait), .cfgPgWait(cfgPgWait), .cfgWrLen(cfgWrLen),
    .cfgTurn(cfgTurn), .cfgTurnExt(cfgTurnExt), .cfgHsEn(cfgHsEn), .cfgDynWait(cfgDynWait),
    .cfgTimeout(cfgTimeout), .memRdy(memRdy), .memDataIn(memDataIn), .memCsN(memCsN),
    .memOeN(memOeN), .memWeN(memWeN), .memAdvN(memAdvN), .memAddr(memAddr),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .doneP(doneP), .rdData(rdData),
    .accErr(accErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCs(input int i, input int mode, input int rd, input int pg,
                       input int wr, input int turn, input bit ext, input bit hs);
    cfgMode[i*3 +: 3]   = 3'(mode);
    cfgRdWait[i*4 +: 4] = 4'(rd);
    cfgPgWait[i*4 +: 4] = 4'(pg);
    cfgWrLen[i*4 +: 4]  = 4'(wr);
    cfgTurn[i*4 +: 4]   = 4'(turn);
    cfgTurnExt[i]       = ext;
    cfgHsEn[i]          = hs;
  endtask

  // Returns on the falling edge where doneP is first seen; lat counts edges since accept.
  task automatic doAccess(input logic [27:0] a, input logic w, input logic pg,
                          input logic [15:0] wd, input int rdyAt,
                          output int lat, output logic [15:0] rd, output logic err,
                          output int advL, output int weL, output int oeL, output int csIdx);
    int n = 1;
    lat = -1; advL = 0; weL = 0; oeL = 0; csIdx = -1; rd = '0; err = 1'b0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqAddr = a; reqWrite = w; reqPage = pg; reqWdata = wd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (n < 300) begin
      if (!memAdvN) advL++;
      if (!memWeN) weL++;
      if (!memOeN) oeL++;
      for (int i = 0; i < 4; i++) if (!memCsN[i]) csIdx = i;
      if (doneP) begin
        lat = n; rd = rdData; err = accErr;
        break;
      end
      if (n == rdyAt) memRdy = 1'b1;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic applyReset(input logic boot);
    rst_n = 1'b0; bootSwap = boot;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  int lat, advL, weL, oeL, cs;
  logic [15:0] rd;
  logic err;

  task automatic tReset();
    chk("R12 csN", memCsN, 4'hF);
    chk("R12 strobes", {memOeN, memWeN, memAdvN}, 3'b111);
    chk("R12 ready/done/err", {reqReady, doneP, accErr, memDataOe}, 4'b1001);
  endtask

  task automatic tBasicRead();
    doAccess(28'h0000100, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R1 latency", lat, 5);
    chk("R1 oe cycles", oeL, 4);
    chk("R11 no-swap region0 cs", cs, 0);
    chk("R10 adv one cycle", advL, 1);
    chk("R13 read data", rd, 16'h0100 ^ 16'h5A5A);
    @(negedge clk);
    chk("R13 done one cycle", doneP, 0);
  endtask

  task automatic tPage();
    doAccess(28'h4000020, 0, 1, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R2 page in mode1", lat, 4);
    doAccess(28'h4000020, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R2 non-page in mode1", lat, 7);
    doAccess(28'h0000020, 0, 1, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R2 page flag ignored mode0", lat, 5);
  endtask

  task automatic tWrite();
    doAccess(28'h8000040, 1, 0, 16'hBEEF, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R3 write latency", lat, 4);
    chk("R3 we cycles", weL, 3);
    chk("R3 oe stays high", oeL, 0);
    @(negedge clk);
    chk("R9 idle bus driven", memDataOe, 1);
    chk("R9 idle bus holds write", memDataOut, 16'hBEEF);
  endtask

  task automatic tHandshake();
    setCs(0, 0, 1, 0, 1, 0, 0, 1);
    memRdy = 1'b0; repeat (4) @(negedge clk);
    doAccess(28'h0000200, 0, 0, 0, 5, lat, rd, err, advL, weL, oeL, cs);
    chk("R4 waits for synced ready", lat, 8);
    chk("R4 no error", err, 0);
    setCs(0, 4, 1, 0, 1, 0, 0, 1);
    doAccess(28'h0000200, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R4 ready already high mode4", lat, 3);
  endtask

  task automatic tNoHandshake();
    memRdy = 1'b0;
    cfgHsEn = 4'hF;
    doAccess(28'h4000010, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R5 mode1 ignores ready", lat, 7);
    doAccess(28'hC000010, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R5 mode7 ignores ready", lat, 4);
    chk("R5 mode7 cs", cs, 3);
    setCs(0, 0, 3, 0, 1, 0, 0, 0);
    doAccess(28'h0000010, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R5 handshake disabled mode0", lat, 5);
  endtask

  task automatic tTimeout();
    memRdy = 1'b0;
    setCs(0, 5, 0, 0, 1, 0, 0, 1);
    cfgTimeout = 8'd3;
    doAccess(28'h0000030, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R6 abort latency", lat, 5);
    chk("R6 error flagged", err, 1);
    @(negedge clk);
    chk("R6 error cleared", accErr, 0);
    cfgTimeout = 8'd20; memRdy = 1'b1;
    setCs(0, 0, 3, 0, 1, 0, 0, 0);
  endtask

  task automatic tTurn();
    setCs(0, 0, 3, 0, 1, 3, 0, 0);
    doAccess(28'h0000000, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R7 same cs read no gap", lat, 5);
    doAccess(28'h4000000, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R7 read to other cs gap", lat, 10);
    doAccess(28'h4000000, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R7 zero turn no gap", lat, 7);
    doAccess(28'h0000000, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    doAccess(28'h0000000, 1, 0, 16'h1234, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R7 read to write gap", lat, 6);
  endtask

  task automatic tWriteBack();
    doAccess(28'h0000456, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    repeat (2) @(negedge clk);
    chk("R9 bus released during delay", memDataOe, 0);
    @(negedge clk);
    chk("R9 bus driven after delay", memDataOe, 1);
    chk("R9 bus holds read data", memDataOut, 16'h0456 ^ 16'h5A5A);
    doAccess(28'h4000078, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R9 delay at least one cycle", memDataOe, 0);
    @(negedge clk);
    chk("R9 minimum delay ends", memDataOe, 1);
    chk("R9 minimum delay data", memDataOut, 16'h0078 ^ 16'h5A5A);
  endtask

  task automatic tExtTurn();
    setCs(2, 0, 0, 0, 2, 2, 1, 0);
    setCs(1, 1, 5, 2, 1, 0, 0, 0);
    doAccess(28'h8000000, 1, 0, 16'h1111, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R8 first write no gap", lat, 4);
    doAccess(28'h8000000, 1, 0, 16'h2222, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R8 same cs negation", lat, 6);
    chk("R8 we width unchanged", weL, 3);
    doAccess(28'h4000000, 1, 0, 16'h3333, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R8 other cs no negation", lat, 3);
  endtask

  task automatic tDyn();
    cfgDynWait = 1'b1;
    doAccess(28'h4000000, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R10 extra cycle", lat, 8);
    chk("R10 adv two cycles", advL, 2);
    cfgDynWait = 1'b0;
  endtask

  task automatic tSwap();
    applyReset(1'b1);
    bootSwap = 1'b0;
    doAccess(28'h0000000, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R11 region0 to cs3", cs, 3);
    chk("R11 cs3 timing", lat, 4);
    doAccess(28'hC000000, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R11 region3 to cs0", cs, 0);
    doAccess(28'h4000000, 0, 0, 0, -1, lat, rd, err, advL, weL, oeL, cs);
    chk("R11 region1 unchanged", cs, 1);
  endtask

  initial begin
    setCs(0, 0, 3, 0, 1, 0, 0, 0);
    setCs(1, 1, 5, 2, 1, 0, 0, 0);
    setCs(2, 0, 0, 0, 2, 0, 0, 0);
    setCs(3, 7, 2, 0, 0, 0, 0, 1);
    applyReset(1'b0);
    tReset();
    tBasicRead();
    tPage();
    tWrite();
    tHandshake();
    tNoHandshake();
    tTimeout();
    tTurn();
    tWriteBack();
    tExtTurn();
    tDyn();
    setCs(0, 0, 3, 0, 1, 0, 0, 0);
    tSwap();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    miss++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule